// File: doc/BRIEF.md
# Serial PCM/ADPCM Frame Port

This block connects a voice codec core to a frame-synchronous serial bus. It runs on a bit clock, and a one-bit-wide sync pulse marks where each frame starts. On the transmit side it takes an 8-bit PCM sample and a 4-bit ADPCM code as parallel values and sends each one out on its own pin, most significant bit first. Both words begin at the rising bit-clock edge on which sync is seen high.

On the receive side there are three serial lanes: the looped-back encoder PCM input, the ADPCM decoder input and the receive PCM input. Each lane rebuilds a parallel word, starting from the bit that arrives together with sync. When the word is complete, the lane holds it and raises a valid strobe for one bit-clock period.

A power-down input forces the serial outputs to their idle levels and drops any word in progress. A new sync pulse always restarts framing, even in the middle of a word. Because sync can be placed freely, a frame can be anywhere from 8 bit clocks long up to any longer length.

Top module: `serial_frame_port`

## Requirements
- R1: The transmit PCM word (8 bits) and the transmit ADPCM code (4 bits) leave MSB first, and they change only on rising BCLK edges. After the rising edge on which sync is sampled high, the output carries bit 7 of the PCM word (bit 3 of the ADPCM code). Each following rising edge presents the next lower bit.
- R2: The parallel transmit values are sampled at the rising edge that sees sync high. Changes to them later in the frame do not alter the word being sent.
- R3: Once the LSB has been sent, each output holds its idle level until the next sync: 0 on the PCM output and 1 on the ADPCM output.
- R4: The encoder PCM lane and the ADPCM decoder lane sample their inputs and sync on the falling edge of BCLK. The bit sampled together with sync is the MSB.
- R5: The receive PCM lane samples its input and sync on the rising edge of BCLK. The bit sampled together with sync is the MSB.
- R6: On the edge that captures a lane's LSB, the assembled word appears on that lane's word output and the lane's valid output goes high for one BCLK period. The word then holds until the next complete word. Serial input bits after the LSB have no effect.
- R7: A sync that arrives in the middle of a word restarts the bit count. The transmit outputs begin the new word at once, and the partial receive words are dropped without a valid strobe.
- R8: While powerDown is high, the PCM output is 0, the ADPCM output is 1 and every valid output is 0, all without waiting for a clock edge. Words in progress are abandoned. After powerDown is released, the outputs stay idle until a sync arrives.
- R9: While rstN is low, the serial outputs sit at their idle levels and every valid and word output is 0.
- R10: Frames as short as 8 BCLK periods can follow one another back to back with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| powerDown | input | 1 | Power-down, active high |
| sync | input | 1 | Frame sync, marks the MSB bit period |
| txPcmWord | input | 8 | Parallel PCM sample to transmit |
| txAdpcmCode | input | 4 | Parallel ADPCM code to transmit |
| encPcmSerIn | input | 1 | Serial looped-back PCM for the encoder (falling-edge sampled) |
| decAdpcmSerIn | input | 1 | Serial ADPCM for the decoder (falling-edge sampled) |
| rxPcmSerIn | input | 1 | Serial receive PCM (rising-edge sampled) |
| pcmTxSer | output | 1 | Serial PCM output |
| adpcmTxSer | output | 1 | Serial ADPCM output |
| encPcmWord | output | 8 | Assembled encoder PCM word |
| encPcmValid | output | 1 | One-period strobe for encPcmWord |
| decAdpcmCode | output | 4 | Assembled ADPCM code |
| decAdpcmValid | output | 1 | One-period strobe for decAdpcmCode |
| rxPcmWord | output | 8 | Assembled receive PCM word |
| rxPcmValid | output | 1 | One-period strobe for rxPcmWord |

## Verification
The hardest case to reach from the ports is a lane that is partway through a word when framing is disturbed, either by a second sync or by power-down. In that case the lane must produce no strobe and keep its old word. A further difficulty is that falling-edge and rising-edge lanes must both see identical sync and data.

The stimulus changes every input a quarter period after the rising edge, so each lane samples a stable value at its own edge. It then cuts a frame short after three bits and starts a new word. It also raises power-down two bits into a frame while continuing to toggle sync and data.

After power-down is released, idle periods without sync show that nothing resumes. The parallel transmit inputs are inverted after every sync edge, so any late sampling of them shows up in the serial output.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  // Strobes from a lane's bit counter to its shift datapath.
  typedef struct packed {
    logic flush;  // power-down: drop word, force idle
    logic start;  // sync seen on this edge: MSB period
    logic step;   // mid-word bit period after the MSB
    logic last;   // this step handles the LSB
  } laneStrobe_t;
endpackage

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
#(
  parameter int W         = 8,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic        bclk,
  input  logic        rstN,
  input  logic        powerDown,
  input  logic        sync,
  output laneStrobe_t strb
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] DONE    = CW'(W);
  localparam logic [CW-1:0] LASTIDX = CW'(W - 1);

  logic [CW-1:0] bitCnt;
  logic [CW-1:0] cntNxt;

  always_comb begin
    strb.flush = powerDown;
    strb.start = sync & ~powerDown;
    strb.step  = ~sync & ~powerDown & (bitCnt != DONE);
    strb.last  = strb.step & (bitCnt == LASTIDX);
    if (strb.flush)      cntNxt = DONE;
    else if (strb.start) cntNxt = CW'(1);
    else if (strb.step)  cntNxt = bitCnt + CW'(1);
    else                 cntNxt = bitCnt;
  end

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge bclk or negedge rstN) begin
        if (!rstN) bitCnt <= DONE;
        else       bitCnt <= cntNxt;
      end
    end else begin : g_rise
      always_ff @(posedge bclk or negedge rstN) begin
        if (!rstN) bitCnt <= DONE;
        else       bitCnt <= cntNxt;
      end
    end
  endgenerate
endmodule

// File: rtl/sfp_txpath.sv
module sfp_txpath
  import sfp_pkg::*;
#(
  parameter int W      = 8,
  parameter bit IDLE   = 1'b0
) (
  input  logic         bclk,
  input  logic         rstN,
  input  laneStrobe_t  strb,
  input  logic [W-1:0] parData,
  output logic         serOut
);
  logic [W-1:0] shReg;
  logic         outBit;

  always_ff @(posedge bclk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      outBit <= IDLE;
    end else if (strb.flush) begin
      shReg  <= '0;
      outBit <= IDLE;
    end else if (strb.start) begin
      shReg  <= {parData[W-2:0], 1'b0};
      outBit <= parData[W-1];
    end else if (strb.step) begin
      shReg  <= strb.last ? '0 : {shReg[W-2:0], 1'b0};
      outBit <= shReg[W-1];
    end else begin
      outBit <= IDLE;
    end
  end

  assign serOut = strb.flush ? IDLE : outBit;
endmodule

// File: rtl/sfp_rxpath.sv
module sfp_rxpath
  import sfp_pkg::*;
#(
  parameter int W         = 8,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic         bclk,
  input  logic         rstN,
  input  laneStrobe_t  strb,
  input  logic         serIn,
  output logic [W-1:0] parOut,
  output logic         validOut
);
  logic [W-2:0] shReg, shNxt;
  logic [W-1:0] wordReg, wordNxt;
  logic         validReg, validNxt;

  always_comb begin
    shNxt    = shReg;
    wordNxt  = wordReg;
    validNxt = 1'b0;
    if (strb.flush) begin
      shNxt = '0;
    end else if (strb.start) begin
      shNxt = (W-1)'(serIn);
    end else if (strb.step) begin
      shNxt = (W-1)'({shReg, serIn});
      if (strb.last) begin
        wordNxt  = {shReg, serIn};
        validNxt = 1'b1;
      end
    end
  end

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge bclk or negedge rstN) begin
        if (!rstN) begin
          shReg <= '0; wordReg <= '0; validReg <= 1'b0;
        end else begin
          shReg <= shNxt; wordReg <= wordNxt; validReg <= validNxt;
        end
      end
    end else begin : g_rise
      always_ff @(posedge bclk or negedge rstN) begin
        if (!rstN) begin
          shReg <= '0; wordReg <= '0; validReg <= 1'b0;
        end else begin
          shReg <= shNxt; wordReg <= wordNxt; validReg <= validNxt;
        end
      end
    end
  endgenerate

  assign parOut   = wordReg;
  assign validOut = validReg & ~strb.flush;
endmodule

// File: rtl/serial_frame_port.sv
module serial_frame_port
  import sfp_pkg::*;
#(
  parameter int PCM_W   = 8,
  parameter int ADPCM_W = 4
) (
  input  logic               bclk,
  input  logic               rstN,
  input  logic               powerDown,
  input  logic               sync,
  input  logic [PCM_W-1:0]   txPcmWord,
  input  logic [ADPCM_W-1:0] txAdpcmCode,
  input  logic               encPcmSerIn,
  input  logic               decAdpcmSerIn,
  input  logic               rxPcmSerIn,
  output logic               pcmTxSer,
  output logic               adpcmTxSer,
  output logic [PCM_W-1:0]   encPcmWord,
  output logic               encPcmValid,
  output logic [ADPCM_W-1:0] decAdpcmCode,
  output logic               decAdpcmValid,
  output logic [PCM_W-1:0]   rxPcmWord,
  output logic               rxPcmValid
);
  laneStrobe_t pcmRiseStrb, adpRiseStrb, pcmFallStrb, adpFallStrb;

  sfp_ctrl #(.W(PCM_W),   .FALL_EDGE(1'b0)) u_ctrlPcmRise (
    .bclk(bclk), .rstN(rstN), .powerDown(powerDown), .sync(sync), .strb(pcmRiseStrb));
  sfp_ctrl #(.W(ADPCM_W), .FALL_EDGE(1'b0)) u_ctrlAdpRise (
    .bclk(bclk), .rstN(rstN), .powerDown(powerDown), .sync(sync), .strb(adpRiseStrb));
  sfp_ctrl #(.W(PCM_W),   .FALL_EDGE(1'b1)) u_ctrlPcmFall (
    .bclk(bclk), .rstN(rstN), .powerDown(powerDown), .sync(sync), .strb(pcmFallStrb));
  sfp_ctrl #(.W(ADPCM_W), .FALL_EDGE(1'b1)) u_ctrlAdpFall (
    .bclk(bclk), .rstN(rstN), .powerDown(powerDown), .sync(sync), .strb(adpFallStrb));

  sfp_txpath #(.W(PCM_W), .IDLE(1'b0)) u_txPcm (
    .bclk(bclk), .rstN(rstN), .strb(pcmRiseStrb), .parData(txPcmWord), .serOut(pcmTxSer));
  sfp_txpath #(.W(ADPCM_W), .IDLE(1'b1)) u_txAdp (
    .bclk(bclk), .rstN(rstN), .strb(adpRiseStrb), .parData(txAdpcmCode), .serOut(adpcmTxSer));

  sfp_rxpath #(.W(PCM_W), .FALL_EDGE(1'b1)) u_rxEnc (
    .bclk(bclk), .rstN(rstN), .strb(pcmFallStrb), .serIn(encPcmSerIn),
    .parOut(encPcmWord), .validOut(encPcmValid));
  sfp_rxpath #(.W(ADPCM_W), .FALL_EDGE(1'b1)) u_rxDec (
    .bclk(bclk), .rstN(rstN), .strb(adpFallStrb), .serIn(decAdpcmSerIn),
    .parOut(decAdpcmCode), .validOut(decAdpcmValid));
  sfp_rxpath #(.W(PCM_W), .FALL_EDGE(1'b0)) u_rxPcm (
    .bclk(bclk), .rstN(rstN), .strb(pcmRiseStrb), .serIn(rxPcmSerIn),
    .parOut(rxPcmWord), .validOut(rxPcmValid));
endmodule

// File: rtl/sfp_chk.sv
module sfp_chk (
  input logic       bclk,
  input logic       rstN,
  input logic       powerDown,
  input logic       sync,
  input logic       pcmMsb,
  input logic       adpMsb,
  input logic       pcmTxSer,
  input logic       adpcmTxSer,
  input logic [7:0] encWord,
  input logic       encValid,
  input logic       decValid,
  input logic [7:0] rxWord,
  input logic       rxValid
);
  logic armed;
  always_ff @(posedge bclk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  AST_PD_IDLE_LEVELS: assert property (@(posedge bclk) disable iff (!rstN)
    powerDown |-> (!pcmTxSer && adpcmTxSer && !rxValid)); // R8
  AST_PCM_MSB_FIRST: assert property (@(posedge bclk) disable iff (!rstN)
    (armed && $past(sync) && !$past(powerDown) && !powerDown) |-> (pcmTxSer == $past(pcmMsb))); // R1
  AST_ADPCM_MSB_FIRST: assert property (@(posedge bclk) disable iff (!rstN)
    (armed && $past(sync) && !$past(powerDown) && !powerDown) |-> (adpcmTxSer == $past(adpMsb))); // R1
  AST_RXPCM_ONE_PULSE: assert property (@(posedge bclk) disable iff (!rstN)
    rxValid |=> !rxValid); // R6
  AST_DEC_ONE_PULSE: assert property (@(negedge bclk) disable iff (!rstN)
    decValid |=> !decValid); // R6
  AST_RXPCM_HOLD: assert property (@(posedge bclk) disable iff (!rstN)
    (armed && !$stable(rxWord)) |-> (rxValid || powerDown)); // R6
  AST_ENC_HOLD: assert property (@(negedge bclk) disable iff (!rstN)
    (armed && !$stable(encWord)) |-> (encValid || powerDown)); // R4
endmodule

bind serial_frame_port sfp_chk u_chk (
  .bclk(bclk), .rstN(rstN), .powerDown(powerDown), .sync(sync),
  .pcmMsb(txPcmWord[PCM_W-1]), .adpMsb(txAdpcmCode[ADPCM_W-1]),
  .pcmTxSer(pcmTxSer), .adpcmTxSer(adpcmTxSer),
  .encWord(encPcmWord[7:0]), .encValid(encPcmValid), .decValid(decAdpcmValid),
  .rxWord(rxPcmWord[7:0]), .rxValid(rxPcmValid));

// File: tb/sim_serial_frame_port.sv
module sim_serial_frame_port;
  localparam int PERIOD = 20;

  typedef struct packed {
    logic [7:0] len;
    logic [7:0] txPcm;
    logic [3:0] txAdp;
    logic [7:0] encPcm;
    logic [3:0] decAdp;
    logic [7:0] rxPcm;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{8'd8,  8'hA5, 4'h9, 8'h3C, 4'h6, 8'hC3},
    '{8'd8,  8'h5A, 4'h6, 8'h81, 4'h1, 8'h7E},
    '{8'd12, 8'hFF, 4'hF, 8'h00, 4'h0, 8'hFF},
    '{8'd20, 8'h00, 4'h0, 8'hFF, 4'hF, 8'h00},
    '{8'd9,  8'h80, 4'h8, 8'h01, 4'h1, 8'h80},
    '{8'd33, 8'h6D, 4'hB, 8'hB2, 4'hD, 8'h4E}
  };

  logic bclk = 1'b0;
  logic rstN = 1'b0;
  logic powerDown = 1'b0;
  logic sync = 1'b0;
  logic [7:0] txPcmWord = '0;
  logic [3:0] txAdpcmCode = '0;
  logic encPcmSerIn = 1'b0, decAdpcmSerIn = 1'b0, rxPcmSerIn = 1'b0;
  logic pcmTxSer, adpcmTxSer, encPcmValid, decAdpcmValid, rxPcmValid;
  logic [7:0] encPcmWord, rxPcmWord;
  logic [3:0] decAdpcmCode;

  int nChk = 0;
  int nFail = 0;

  serial_frame_port u0 (
    .bclk(bclk), .rstN(rstN), .powerDown(powerDown), .sync(sync),
    .txPcmWord(txPcmWord), .txAdpcmCode(txAdpcmCode),
    .encPcmSerIn(encPcmSerIn), .decAdpcmSerIn(decAdpcmSerIn), .rxPcmSerIn(rxPcmSerIn),
    .pcmTxSer(pcmTxSer), .adpcmTxSer(adpcmTxSer),
    .encPcmWord(encPcmWord), .encPcmValid(encPcmValid),
    .decAdpcmCode(decAdpcmCode), .decAdpcmValid(decAdpcmValid),
    .rxPcmWord(rxPcmWord), .rxPcmValid(rxPcmValid));

  always #(PERIOD/2) bclk = ~bclk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Entered and left at rising edge + PERIOD/4.
  task automatic runFrame(input vec_t v, input int n);
    for (int i = 0; i < n; i++) begin
      sync          = (i == 0);
      txPcmWord     = (i == 0) ? v.txPcm : ~v.txPcm;   // R2 tamper after sync
      txAdpcmCode   = (i == 0) ? v.txAdp : ~v.txAdp;
      encPcmSerIn   = (i < 8) ? v.encPcm[7-i] : i[0];
      decAdpcmSerIn = (i < 4) ? v.decAdp[3-i] : i[1];
      rxPcmSerIn    = (i < 8) ? v.rxPcm[7-i]  : ~i[0];
      @(negedge bclk); #(PERIOD/4);
      check("R4 encPcmValid", {7'd0, encPcmValid}, {7'd0, i == 7});
      check("R4 decAdpcmValid", {7'd0, decAdpcmValid}, {7'd0, i == 3});
      if (i == 7) check("R4 encPcmWord", encPcmWord, v.encPcm);
      if (i == 3) check("R4 decAdpcmCode", {4'd0, decAdpcmCode}, {4'd0, v.decAdp});
      @(posedge bclk); #(PERIOD/4);
      check("R1 R2 R3 pcmTxSer", {7'd0, pcmTxSer}, {7'd0, (i < 8) ? v.txPcm[7-i] : 1'b0});
      check("R1 R2 R3 adpcmTxSer", {7'd0, adpcmTxSer}, {7'd0, (i < 4) ? v.txAdp[3-i] : 1'b1});
      check("R5 R6 rxPcmValid", {7'd0, rxPcmValid}, {7'd0, i == 7});
      if (i == 7) check("R5 rxPcmWord", rxPcmWord, v.rxPcm);
      if (i == n - 1 && i > 7) begin
        check("R6 encPcmWord hold", encPcmWord, v.encPcm);
        check("R6 decAdpcmCode hold", {4'd0, decAdpcmCode}, {4'd0, v.decAdp});
        check("R6 rxPcmWord hold", rxPcmWord, v.rxPcm);
      end
    end
    sync = 1'b0;
  endtask

  task automatic idleCycles(input int n, input string req, input logic [7:0] eEnc,
                            input logic [3:0] eDec, input logic [7:0] eRx);
    sync = 1'b0;
    for (int k = 0; k < n; k++) begin
      encPcmSerIn = k[0]; decAdpcmSerIn = ~k[0]; rxPcmSerIn = k[1];
      @(posedge bclk); #(PERIOD/4);
      check({req, " pcm idle"}, {7'd0, pcmTxSer}, 8'd0);
      check({req, " adpcm idle"}, {7'd0, adpcmTxSer}, 8'd1);
      check({req, " valids"}, {5'd0, encPcmValid, decAdpcmValid, rxPcmValid}, 8'd0);
    end
    check({req, " encPcmWord"}, encPcmWord, eEnc);
    check({req, " decAdpcmCode"}, {4'd0, decAdpcmCode}, {4'd0, eDec});
    check({req, " rxPcmWord"}, rxPcmWord, eRx);
  endtask

  initial begin
    #(PERIOD * 200000);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    vec_t a, b, c;
    // R9: reset state while rstN is low
    #(PERIOD/2 + PERIOD/4);
    check("R9 pcmTxSer", {7'd0, pcmTxSer}, 8'd0);
    check("R9 adpcmTxSer", {7'd0, adpcmTxSer}, 8'd1);
    check("R9 valids", {5'd0, encPcmValid, decAdpcmValid, rxPcmValid}, 8'd0);
    check("R9 words", encPcmWord | rxPcmWord | {4'd0, decAdpcmCode}, 8'd0);
    @(posedge bclk); #(PERIOD/4);
    rstN = 1'b1;
    idleCycles(3, "R9 R3 after reset", 8'h00, 4'h0, 8'h00);

    // Vector table, back-to-back frames (R10 for length 8)
    for (int v = 0; v < NV; v++) runFrame(VEC[v], int'(VEC[v].len));

    // R7: sync in the middle of a word restarts all lanes
    a = '{8'd8, 8'hF0, 4'hC, 8'hF0, 4'hC, 8'h0F};
    b = '{8'd10, 8'h3B, 4'h5, 8'hD4, 4'hA, 8'h29};
    runFrame(a, 3);
    runFrame(b, int'(b.len));   // R7: no strobe from a, b sent from its MSB

    // R8: power-down two bits into a frame
    c = '{8'd8, 8'hFF, 4'h0, 8'h77, 4'h7, 8'h66};
    runFrame(c, 2);
    powerDown = 1'b1;
    #1;
    check("R8 pcm low at once", {7'd0, pcmTxSer}, 8'd0);
    check("R8 adpcm high at once", {7'd0, adpcmTxSer}, 8'd1);
    for (int k = 0; k < 4; k++) begin
      sync = (k == 1);
      encPcmSerIn = 1'b1; decAdpcmSerIn = 1'b1; rxPcmSerIn = 1'b1;
      @(negedge bclk); #(PERIOD/4);
      check("R8 falling valids", {6'd0, encPcmValid, decAdpcmValid}, 8'd0);
      @(posedge bclk); #(PERIOD/4);
      check("R8 pcmTxSer", {7'd0, pcmTxSer}, 8'd0);
      check("R8 adpcmTxSer", {7'd0, adpcmTxSer}, 8'd1);
      check("R8 rxPcmValid", {7'd0, rxPcmValid}, 8'd0);
    end
    powerDown = 1'b0;
    idleCycles(12, "R8 after release", b.encPcm, b.decAdp, b.rxPcm);
    runFrame(VEC[1], 8);   // R8: normal operation resumes on sync

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule